// File: doc/BRIEF.md
# System Tick Down-Counter

This block is a memory-mapped periodic timer for a processor subsystem. Software programs a 24-bit reload value, then turns the timer on. The counter loads that value and counts down. Each time it passes zero it sets a sticky wrap flag and, if software has asked for it, raises a one-cycle tick interrupt pulse toward the interrupt controller. The count decrements either on every core clock or only on cycles where a single-cycle reference-enable strobe is high. A control bit picks the source.

Software reaches four 32-bit registers over a simple bus: control/status, reload, current value and a fixed calibration word. Reading control/status clears the wrap flag. Writing any value to the current-value register restarts the count and also clears the flag. A reload value of zero makes the timer fire once and then park at zero instead of repeating.

The counter is a three-state machine:
- OFF: disabled, count held at zero.
- RUN: counting.
- HALT: expired with a zero reload, count held at zero.

The transitions are:
- START moves OFF, RUN or HALT to RUN and loads the reload value.
- STOP moves RUN or HALT to OFF.
- WRAP_RELOAD keeps RUN in RUN and loads the reload value again.
- WRAP_PARK moves RUN to HALT.
- STEP keeps RUN in RUN and decrements the count.

Top module: `tick_timer`

## Requirements
- R1: After reset, the control, reload and current-value registers read as zero. The wrap flag and the interrupt pulse are low.
- R2: The control register sits at offset 0x10. A control write stores only bit 0 (enable), bit 1 (interrupt enable) and bit 2 (clock source); every other bit reads as zero. Bit 16 reads the wrap flag and cannot be written. The reload register sits at offset 0x14 and keeps only the low 24 bits of a write; the upper 8 bits read as zero.
- R3: A control write that changes enable from 0 to 1 loads the reload value into the counter. From then on, a wrap occurs once every reload+1 counting ticks. The current-value register at offset 0x18 reads the count.
- R4: A wrap is the counting tick taken while the count is zero. A wrap sets the wrap flag (control bit 16 and the `wrap_flag` output). The `tick_irq` output pulses high for exactly one cycle, one cycle after the wrap edge, only if the interrupt enable was set.
- R5: A control read returns the flag value held before the read, and the flag is cleared at that edge. A wrap in the same cycle leaves the flag set.
- R6: A write of any value to the current-value register clears the wrap flag. If the timer is enabled, the write also restarts the count from the reload value.
- R7: When a wrap occurs with a reload value of zero, the counter parks at zero and produces no further wraps until it is restarted.
- R8: A control write with bit 0 clear stops the counter. While enable is 0, the current-value register reads zero and no wraps occur.
- R9: With bit 2 set, the counter moves on every clock cycle. With bit 2 clear, it moves only on cycles where `ref_stb` is high.
- R10: A control write that keeps enable at 1 but changes bit 2 reloads the counter.
- R11: The calibration register at offset 0x1C reads the constant `CAL_VALUE`, and writes to it have no effect. Reads at unmapped offsets return zero, and so does `bus_rdata` when no read strobe is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_stb | input | 1 | Single-cycle reference counting enable |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| tick_irq | output | 1 | One-cycle tick interrupt pulse |
| wrap_flag | output | 1 | Sticky wrap flag (control bit 16) |

## Verification
The counter is exercised with several reload values (4, 2, 3 and 0), with both clock sources, and with interrupts enabled and then disabled.

Measuring the interval between pulses separates a correct period of reload+1 from an off-by-one. The reference-strobe run, with a strobe every third cycle, shows whether ticks are being gated.

Back-to-back control reads overlap with wraps, which exposes any loss of a flag that is set and cleared in the same cycle. The zero-reload run separates a parked counter from one that free-runs at zero. Clock-source changes and current-value writes made while enabled confirm that both restart the count.

// File: rtl/tick_pkg.sv
package tick_pkg;
    // Register byte offsets
    localparam logic [7:0] OFS_CTRL   = 8'h10;
    localparam logic [7:0] OFS_RELOAD = 8'h14;
    localparam logic [7:0] OFS_CUR    = 8'h18;
    localparam logic [7:0] OFS_CAL    = 8'h1C;

    // Control register bit positions
    localparam int CB_EN   = 0;
    localparam int CB_IE   = 1;
    localparam int CB_SRC  = 2;
    localparam int CB_FLAG = 16;

    typedef enum logic [1:0] {
        CNT_OFF  = 2'd0,
        CNT_RUN  = 2'd1,
        CNT_HALT = 2'd2
    } cnt_state_t;
endpackage

// File: rtl/tick_regs.sv
module tick_regs
    import tick_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              ref_stb,
    input  logic              wrap,
    output logic              ctrl_en,
    output logic              ctrl_ie,
    output logic              ctrl_src,
    output logic [CNT_W-1:0]  reload_val,
    output logic              flag,
    output logic              irq,
    output logic              start,
    output logic              stop,
    output logic              tick
);
    logic wr_ctrl, wr_reload, wr_cur, rd_ctrl;

    assign wr_ctrl   = wr && (addr == ADDR_W'(OFS_CTRL));
    assign wr_reload = wr && (addr == ADDR_W'(OFS_RELOAD));
    assign wr_cur    = wr && (addr == ADDR_W'(OFS_CUR));
    assign rd_ctrl   = rd && (addr == ADDR_W'(OFS_CTRL));

    // Counter commands
    always_comb begin
        start = 1'b0;
        stop  = 1'b0;
        if (wr_ctrl) begin
            if (!wdata[CB_EN])
                stop = 1'b1;
            else if (!ctrl_en || (wdata[CB_SRC] != ctrl_src))
                start = 1'b1;
        end
        if (wr_cur && ctrl_en)
            start = 1'b1;
    end

    assign tick = ctrl_src ? 1'b1 : ref_stb;

    // Control and reload storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_en    <= 1'b0;
            ctrl_ie    <= 1'b0;
            ctrl_src   <= 1'b0;
            reload_val <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_en  <= wdata[CB_EN];
                ctrl_ie  <= wdata[CB_IE];
                ctrl_src <= wdata[CB_SRC];
            end
            if (wr_reload)
                reload_val <= wdata[CNT_W-1:0];
        end
    end

    // Flag and interrupt pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
            irq  <= 1'b0;
        end else begin
            irq <= wrap && ctrl_ie;
            if (wrap)
                flag <= 1'b1;
            else if (rd_ctrl || wr_cur)
                flag <= 1'b0;
        end
    end

    // R5
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ctrl && !wrap) |=> !flag);

    // R4
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag && $past(ctrl_ie)));

    // R4
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
endmodule

// File: rtl/tick_counter.sv
module tick_counter
    import tick_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic             tick,
    input  logic             src_core,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    cnt_state_t st, st_nxt;
    logic [CNT_W-1:0] cnt_nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= CNT_OFF;
        else        st <= st_nxt;
    end

    // Next state and transitions
    always_comb begin
        st_nxt = st;
        unique case (st)
            CNT_OFF: begin
                if (start && !stop) st_nxt = CNT_RUN;
            end
            CNT_RUN: begin
                if (stop)
                    st_nxt = CNT_OFF;
                else if (!start && tick && (cnt == '0) && (reload_val == '0))
                    st_nxt = CNT_HALT;
            end
            CNT_HALT: begin
                if (stop)       st_nxt = CNT_OFF;
                else if (start) st_nxt = CNT_RUN;
            end
            default: st_nxt = CNT_OFF;
        endcase
    end

    // Count value and wrap output
    always_comb begin
        cnt_nxt = cnt;
        wrap    = 1'b0;
        unique case (st)
            CNT_OFF: begin
                cnt_nxt = (start && !stop) ? reload_val : '0;
            end
            CNT_RUN: begin
                if (stop)
                    cnt_nxt = '0;
                else if (start)
                    cnt_nxt = reload_val;
                else if (tick) begin
                    if (cnt == '0) begin
                        wrap    = 1'b1;
                        cnt_nxt = reload_val;
                    end else begin
                        cnt_nxt = cnt - 1'b1;
                    end
                end
            end
            CNT_HALT: begin
                cnt_nxt = (start && !stop) ? reload_val : '0;
            end
            default: cnt_nxt = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_nxt;
    end

    // R3
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !stop) |=> (cnt == $past(reload_val)));

    // R7
    halt_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CNT_HALT && !start && !stop) |=> (st == CNT_HALT && cnt == '0));

    // R9
    ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CNT_RUN && !src_core && !tick && !start && !stop) |=> $stable(cnt));
endmodule

// File: rtl/tick_rdmux.sv
module tick_rdmux
    import tick_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          CNT_W     = 24,
    parameter logic [31:0] CAL_VALUE = 32'h4000_3A98
) (
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ctrl_en,
    input  logic              ctrl_ie,
    input  logic              ctrl_src,
    input  logic              flag,
    input  logic [CNT_W-1:0]  reload_val,
    input  logic [CNT_W-1:0]  cnt,
    output logic [31:0]       rdata
);
    always_comb begin
        rdata = '0;
        if (rd) begin
            if (addr == ADDR_W'(OFS_CTRL)) begin
                rdata[CB_EN]   = ctrl_en;
                rdata[CB_IE]   = ctrl_ie;
                rdata[CB_SRC]  = ctrl_src;
                rdata[CB_FLAG] = flag;
            end else if (addr == ADDR_W'(OFS_RELOAD)) begin
                rdata = 32'(reload_val);
            end else if (addr == ADDR_W'(OFS_CUR)) begin
                rdata = ctrl_en ? 32'(cnt) : 32'd0;
            end else if (addr == ADDR_W'(OFS_CAL)) begin
                rdata = CAL_VALUE;
            end
        end
    end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          CNT_W     = 24,
    parameter logic [31:0] CAL_VALUE = 32'h4000_3A98
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_stb,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              tick_irq,
    output logic              wrap_flag
);
    logic             ctrl_en, ctrl_ie, ctrl_src;
    logic [CNT_W-1:0] reload_val, cnt;
    logic             start, stop, tick, wrap;

    tick_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
        .wdata(bus_wdata), .ref_stb(ref_stb), .wrap(wrap),
        .ctrl_en(ctrl_en), .ctrl_ie(ctrl_ie), .ctrl_src(ctrl_src),
        .reload_val(reload_val), .flag(wrap_flag), .irq(tick_irq),
        .start(start), .stop(stop), .tick(tick)
    );

    tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .tick(tick),
        .src_core(ctrl_src), .reload_val(reload_val), .cnt(cnt), .wrap(wrap)
    );

    tick_rdmux #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CAL_VALUE(CAL_VALUE)) u_rd (
        .rd(bus_rd), .addr(bus_addr), .ctrl_en(ctrl_en), .ctrl_ie(ctrl_ie),
        .ctrl_src(ctrl_src), .flag(wrap_flag), .reload_val(reload_val),
        .cnt(cnt), .rdata(bus_rdata)
    );

    // R8
    off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |-> (cnt == '0 && !wrap));
endmodule

// File: tb/tb_tick_timer.sv
`timescale 1ns/1ps
module tb_tick_timer;
    localparam logic [31:0] CAL = 32'h4000_3A98;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_stb = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = 8'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        tick_irq, wrap_flag;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    int ref_ph = 0;

    tick_timer #(.ADDR_W(8), .CNT_W(24), .CAL_VALUE(CAL)) dut (
        .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .tick_irq(tick_irq), .wrap_flag(wrap_flag)
    );

    always #4 clk = ~clk;

    // Reference model state
    int  m_st = 0;           // 0 off, 1 run, 2 parked
    int  m_cnt = 0;
    int  m_reload = 0;
    bit  m_en = 0, m_ie = 0, m_src = 0, m_flag = 0, m_irq = 0;
    bit  wc, wl, wu, rc, tk, sta, stp, wr_ev;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_reload = 0;
            m_en = 0; m_ie = 0; m_src = 0; m_flag = 0; m_irq = 0;
        end else begin
            wc  = bus_wr && bus_addr == 8'h10;
            wl  = bus_wr && bus_addr == 8'h14;
            wu  = bus_wr && bus_addr == 8'h18;
            rc  = bus_rd && bus_addr == 8'h10;
            tk  = m_src ? 1'b1 : ref_stb;
            stp = wc && !bus_wdata[0];
            sta = (wc && bus_wdata[0] && (!m_en || bus_wdata[2] != m_src)) || (wu && m_en);
            wr_ev = 0;
            if (stp) begin m_st = 0; m_cnt = 0; end
            else if (sta) begin m_st = 1; m_cnt = m_reload; end
            else if (m_st == 1 && tk) begin
                if (m_cnt == 0) begin
                    wr_ev = 1;
                    if (m_reload == 0) m_st = 2;
                    else m_cnt = m_reload;
                end else m_cnt = m_cnt - 1;
            end
            m_irq = wr_ev && m_ie;
            if (wr_ev) m_flag = 1;
            else if (rc || wu) m_flag = 0;
            if (wc) begin m_en = bus_wdata[0]; m_ie = bus_wdata[1]; m_src = bus_wdata[2]; end
            if (wl) m_reload = int'(bus_wdata[23:0]);
        end
    end

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        case (a)
            8'h10:   return {15'b0, m_flag, 13'b0, m_src, m_ie, m_en};
            8'h14:   return 32'(m_reload);
            8'h18:   return m_en ? 32'(m_cnt) : 32'd0;
            8'h1C:   return CAL;
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R4 irq", 32'(tick_irq), 32'(m_irq));
            chk("R4 flag", 32'(wrap_flag), 32'(m_flag));
            if (bus_rd) begin
                if (bus_addr == 8'h10)      chk("R5 ctrl read", bus_rdata, exp_rd(bus_addr));
                else if (bus_addr == 8'h18) chk("R3 current read", bus_rdata, exp_rd(bus_addr));
                else if (bus_addr == 8'h14) chk("R2 reload read", bus_rdata, exp_rd(bus_addr));
                else                        chk("R11 other read", bus_rdata, exp_rd(bus_addr));
            end else begin
                chk("R11 idle rdata", bus_rdata, 32'd0);
            end
        end
    end

    // Reference strobe: high on every third cycle
    initial begin
        forever begin
            @(posedge clk); #1;
            ref_ph = (ref_ph + 1) % 3;
            ref_stb = (ref_ph == 0);
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        bus_rd = 1; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
    endtask

    task automatic irq_period(output int p);
        int guard = 0;
        @(negedge clk);
        while (!tick_irq && guard < 1000) begin @(negedge clk); guard++; end
        p = 0;
        @(negedge clk); p++;
        while (!tick_irq && p < 1000) begin @(negedge clk); p++; end
    endtask

    task automatic count_irq(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (tick_irq) c++;
        end
    endtask

    task automatic finish_run;
        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        int p, c;
        idle(3);
        @(negedge clk);
        chk("R1 irq at reset", 32'(tick_irq), 32'd0);
        chk("R1 flag at reset", 32'(wrap_flag), 32'd0);
        rst_n = 1;
        bus_read(8'h10, d); chk("R1 ctrl after reset", d, 32'd0);
        bus_read(8'h14, d); chk("R1 reload after reset", d, 32'd0);
        bus_read(8'h18, d); chk("R1 current after reset", d, 32'd0);

        // R2: field masking
        bus_write(8'h14, 32'hFFFF_FFFF);
        bus_read(8'h14, d); chk("R2 reload masked", d, 32'h00FF_FFFF);
        bus_write(8'h10, 32'hFFFF_FFF8);
        bus_read(8'h10, d); chk("R2 ctrl upper bits", d, 32'd0);

        // R3/R4: core clock, reload 4, period 5
        bus_write(8'h14, 32'd4);
        bus_write(8'h10, 32'h7);
        bus_read(8'h18, d); chk("R3 loaded on enable", d, 32'd3);
        irq_period(p); chk("R3 period reload+1", 32'(p), 32'd5);

        // R5: clear on read
        bus_read(8'h10, d); chk("R5 flag seen", 32'(d[16]), 32'd1);
        bus_read(8'h10, d);
        // back-to-back control reads overlapping with wraps
        for (int i = 0; i < 30; i++) begin
            @(posedge clk); #1; bus_rd = 1; bus_addr = 8'h10;
        end
        @(posedge clk); #1; bus_rd = 0;

        // R4: interrupt disabled still sets flag
        bus_write(8'h10, 32'h5);
        count_irq(15, c); chk("R4 no irq when disabled", 32'(c), 32'd0);
        chk("R4 flag without irq", 32'(wrap_flag), 32'd1);

        // R6: current write clears flag and restarts
        bus_write(8'h18, 32'hDEAD_BEEF);
        chk("R6 flag cleared", 32'(wrap_flag), 32'd0);
        bus_read(8'h18, d); chk("R6 restarted", d, 32'd3);

        // R10 + R9: switch to reference strobe, reload 2, period 9
        bus_write(8'h14, 32'd2);
        bus_write(8'h10, 32'h3);
        bus_read(8'h18, d); chk("R10 reload on source change", 32'(d <= 2), 32'd1);
        irq_period(p); chk("R9 reference period", 32'(p), 32'd9);
        irq_period(p); chk("R9 reference period repeat", 32'(p), 32'd9);

        // R8: disable
        bus_write(8'h10, 32'h2);
        bus_read(8'h18, d); chk("R8 current zero when off", d, 32'd0);
        count_irq(20, c); chk("R8 no wraps when off", 32'(c), 32'd0);

        // R7: zero reload parks after one wrap
        bus_write(8'h14, 32'd0);
        bus_write(8'h10, 32'h7);
        count_irq(20, c); chk("R7 single wrap", 32'(c), 32'd1);
        bus_read(8'h18, d); chk("R7 parked at zero", d, 32'd0);
        bus_write(8'h18, 32'd1);
        count_irq(20, c); chk("R7 restart gives one wrap", 32'(c), 32'd1);

        // R11: calibration and unmapped
        bus_read(8'h1C, d); chk("R11 calibration", d, CAL);
        bus_write(8'h1C, 32'h1234_5678);
        bus_read(8'h1C, d); chk("R11 calibration read-only", d, CAL);
        bus_read(8'h20, d); chk("R11 unmapped", d, 32'd0);

        bus_write(8'h10, 32'h0);
        idle(3);
        finish_run();
    end
endmodule